// File: doc/BRIEF.md
# Sixteen-bit dual-stack Forth processor core

The core is a small 16-bit processor with two stacks, one for data and one for return addresses. It executes one Forth-style instruction per clock. The top of the data stack lives in a register, T. The element beneath it, N, and all deeper entries live in a small register-file stack. The return stack works the same way and its top entry is called R.

The core is built around a single pseudo-dual-port memory. That memory has a read port and a write port. Both can work in the same cycle on different addresses, but neither can change direction. The read port fetches the next instruction on every cycle. A data load therefore takes the read port away from fetch for one extra "alternate" cycle, and the program sees this as a one-cycle stall. Because loads are requested by a flag bit rather than by an operation code, the ALU slot a fetch would have used is free, and it now performs a subtract (N-T).

Stores and loads whose address has bit 14 set are sent to a simple strobe interface for I/O instead of to memory.

Top module: `stk16_cpu`

## Requirements
- R1: While reset is held, the read address is 0 and no write, I/O read or I/O write strobe is active. After reset the core fetches from address 0 with both stacks empty.
- R2: An instruction with bit 15 set is a literal. It pushes {1'b0, insn[14:0]} onto the data stack, and the old T moves into N.
- R3: When bit 15 is clear, bits 14:13 choose the instruction kind. 00 jumps to insn[12:0]. 01 pops T and jumps to insn[12:0] only if the popped value was zero; otherwise it continues at pc+1.
- R4: Kind 10 is a call: it pushes pc+1 onto the return stack and jumps to insn[12:0]. An ALU instruction with bit 7 set continues at R.
- R5: Kind 11 is an ALU instruction with these fields. Bits 11:8 are the operation. Bit 12 requests a load. Bit 6 copies the old T into the new N slot. Bit 5 copies the old T into the new R slot. Bit 4 stores N at address T. Bits 3:2 are the return-stack delta and bits 1:0 the data-stack delta, each a 2-bit signed value (01=+1, 11=-1, 10=-2).
- R6: The operation codes are: 0 T, 1 N, 2 T+N, 3 T&N, 4 T|N, 5 T^N, 6 ~T, 7 N==T, 8 signed N<T, 9 N>>T[3:0], 10 T-1, 11 R, 12 N-T, 13 N<<T[3:0], 14 depth, 15 unsigned N<T. Comparison results are all-ones for true and zero for false.
- R7: A store writes N to address T. If T[14]=0 it uses the memory write port at T[AW-1:0]. If T[14]=1 it pulses io_wr with io_addr=T and io_wdata=N.
- R8: A load drives address T during the instruction's own cycle. The following cycle is an alternate cycle: no instruction executes, no strobe is active, and T takes mem_rdata (T[14]=0) or io_rdata (T[14]=1, signalled by an io_rd pulse). A load therefore costs exactly one extra cycle.
- R9: Read data arrives the cycle after its address. Outside loads, the core drives the address of the next instruction every cycle, so straight-line code runs one instruction per clock.
- R10: Each stack holds 16 memory entries below its top. Going past that depth wraps the pointer silently and overwrites the oldest entry.
- R11: The depth operation returns the data-stack pointer, zero-extended. From an empty reset stack, it counts the pushes minus the pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_raddr | output | AW | Read-port address, either for fetch or for a load |
| mem_rdata | input | 16 | Read-port data, valid one cycle after its address |
| mem_we | output | 1 | Write-port enable |
| mem_waddr | output | AW | Write-port address |
| mem_wdata | output | 16 | Write-port data |
| io_rd | output | 1 | I/O read strobe; data is expected on the next cycle |
| io_wr | output | 1 | I/O write strobe |
| io_addr | output | 16 | I/O address (T) |
| io_wdata | output | 16 | I/O write data (N) |
| io_rdata | input | 16 | I/O read data |

## Verification
Stack wrap-around is the hardest case to reach from the ports. It only becomes visible after more than sixteen pushes, followed by enough pops to bring the overwritten slot back to the top. The program pushes eighteen literals and drops seventeen of them, and the value then left in T shows that the entry was overwritten rather than kept. The load stall is also only visible in timing, so the bench timestamps each I/O write. It compares the cycle gap around a load with the gap around an equal-length sequence that has no load.

// File: rtl/stk16_cpu.sv
module stk16_cpu #(
  parameter int AW  = 12,
  parameter int SDW = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_raddr,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [15:0]   mem_wdata,
  output logic          io_rd,
  output logic          io_wr,
  output logic [15:0]   io_addr,
  output logic [15:0]   io_wdata,
  input  logic [15:0]   io_rdata
);
  localparam int PCW = AW + 1;
  localparam int SD  = 1 << SDW;

  typedef enum logic [1:0] {S_BOOT, S_RUN, S_ALT} st_t;

  st_t st, st_n;
  logic [PCW-1:0] pc, pc_n, pc_inc;
  logic [15:0] T, T_n, N, R, alu;
  logic [SDW-1:0] dsp, dsp_n, rsp, rsp_n, dd, rdl;
  logic [15:0] dstk [SD];
  logic [15:0] rstk [SD];
  logic dwr, rwr, ld_io;
  logic [15:0] rwval;

  wire [15:0] insn   = mem_rdata;
  wire        run    = (st == S_RUN);
  wire        is_lit = run & insn[15];
  wire [1:0]  kind   = insn[14:13];
  wire        is_alu = run & ~insn[15] & (kind == 2'b11);
  wire        f_ld   = insn[12];
  wire [3:0]  aop    = insn[11:8];
  wire        f_ret  = insn[7];
  wire        f_tn   = insn[6];
  wire        f_tr   = insn[5];
  wire        f_st   = insn[4];
  wire [PCW-1:0] target = insn[PCW-1:0];

  assign N      = dstk[dsp];
  assign R      = rstk[rsp];
  assign pc_inc = pc + 1'b1;
  assign dd     = {{(SDW-2){insn[1]}}, insn[1:0]};
  assign rdl    = {{(SDW-2){insn[3]}}, insn[3:2]};

  always_comb begin
    case (aop)
      4'd0:  alu = T;
      4'd1:  alu = N;
      4'd2:  alu = T + N;
      4'd3:  alu = T & N;
      4'd4:  alu = T | N;
      4'd5:  alu = T ^ N;
      4'd6:  alu = ~T;
      4'd7:  alu = {16{N == T}};
      4'd8:  alu = {16{$signed(N) < $signed(T)}};
      4'd9:  alu = N >> T[3:0];
      4'd10: alu = T - 16'd1;
      4'd11: alu = R;
      4'd12: alu = N - T;
      4'd13: alu = N << T[3:0];
      4'd14: alu = 16'(dsp);
      default: alu = {16{N < T}};
    endcase
  end

  always_comb begin
    st_n  = st;
    pc_n  = pc;
    T_n   = T;
    dsp_n = dsp;
    rsp_n = rsp;
    dwr   = 1'b0;
    rwr   = 1'b0;
    rwval = T;
    case (st)
      S_BOOT: st_n = S_RUN;
      S_ALT: begin
        T_n  = ld_io ? io_rdata : mem_rdata;
        st_n = S_RUN;
      end
      default: begin
        if (insn[15]) begin
          T_n   = {1'b0, insn[14:0]};
          dsp_n = dsp + 1'b1;
          dwr   = 1'b1;
          pc_n  = pc_inc;
        end else begin
          case (kind)
            2'b00: pc_n = target;
            2'b01: begin
              pc_n  = (T == 16'd0) ? target : pc_inc;
              T_n   = N;
              dsp_n = dsp - 1'b1;
            end
            2'b10: begin
              pc_n  = target;
              rsp_n = rsp + 1'b1;
              rwr   = 1'b1;
              rwval = 16'(pc_inc);
            end
            default: begin
              T_n   = alu;
              dsp_n = dsp + dd;
              rsp_n = rsp + rdl;
              dwr   = f_tn;
              rwr   = f_tr;
              pc_n  = f_ret ? R[PCW-1:0] : pc_inc;
              if (f_ld) st_n = S_ALT;
            end
          endcase
        end
      end
    endcase
  end

  always_comb begin
    if (is_alu && f_ld) mem_raddr = T[AW-1:0];
    else if (st == S_RUN) mem_raddr = pc_n[AW-1:0];
    else mem_raddr = pc[AW-1:0];
  end

  assign mem_we    = is_alu & f_st & ~T[14];
  assign mem_waddr = T[AW-1:0];
  assign mem_wdata = N;
  assign io_wr     = is_alu & f_st & T[14];
  assign io_rd     = is_alu & f_ld & T[14];
  assign io_addr   = T;
  assign io_wdata  = N;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_BOOT;
      pc    <= '0;
      T     <= '0;
      dsp   <= '0;
      rsp   <= '0;
      ld_io <= 1'b0;
    end else begin
      st  <= st_n;
      pc  <= pc_n;
      T   <= T_n;
      dsp <= dsp_n;
      rsp <= rsp_n;
      if (is_alu && f_ld) ld_io <= T[14];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && dwr) dstk[dsp_n] <= T;
    if (!rst && rwr) rstk[rsp_n] <= rwval;
  end

  p_lit_push_r2: assert property (@(posedge clk) disable iff (rst)
    is_lit |=> (T == {1'b0, $past(insn[14:0])}) && (dsp == $past(dsp) + 1'b1));

  p_cond_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !insn[15] && kind == 2'b01) |=> (dsp == $past(dsp) - 1'b1));

  p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !insn[15] && kind == 2'b10) |=> (R == 16'($past(pc_inc))) && (pc == $past(target)));

  p_alt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (is_alu && f_ld) |=> (!mem_we && !io_wr && !io_rd && mem_raddr == $past(pc_n[AW-1:0])));
endmodule

// File: tb/sim_stk16_cpu.sv
module sim_stk16_cpu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [11:0] mem_raddr, mem_waddr;
  logic [15:0] mem_rdata, mem_wdata, io_addr, io_wdata;
  logic [15:0] io_rdata = 16'd0;
  logic mem_we, io_rd, io_wr;

  stk16_cpu u0 (.clk(clk), .rst(rst), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .io_rd(io_rd),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata));

  logic [15:0] ram [0:4095];
  logic ld_we = 1'b0;
  logic [11:0] ld_a = '0;
  logic [15:0] ld_d = '0;
  always @(posedge clk) begin
    if (ld_we) ram[ld_a] <= ld_d;
    else if (mem_we) ram[mem_waddr] <= mem_wdata;
    mem_rdata <= ram[mem_raddr];
    if (io_rd) io_rdata <= 16'h5A00 | {8'h00, io_addr[7:0]};
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0, pa = 0, n_exp = 0, nwr = 0;
  int wr_cyc [0:63];
  logic [15:0] q_addr[$];
  logic [15:0] q_data[$];
  string q_tag[$];

  always @(negedge clk) begin
    if (!rst && io_wr) begin
      if (nwr < 64) wr_cyc[nwr] = cyc;
      nwr++;
      nchk++;
      if (q_data.size() == 0) begin
        nfail++;
        $display("FAIL R3 unexpected io write addr=%h data=%h, expected none", io_addr, io_wdata);
      end else begin
        logic [15:0] ea, ed;
        string et;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        et = q_tag.pop_front();
        if (io_addr !== ea || io_wdata !== ed) begin
          nfail++;
          $display("FAIL %s io write addr=%h data=%h, expected addr=%h data=%h", et, io_addr, io_wdata, ea, ed);
        end
      end
    end
  end

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    ld_we = 1'b1;
    ld_a  = 12'(pa);
    ld_d  = w;
    pa++;
  endtask

  task automatic lit(input int v);
    put(16'h8000 | 16'(v & 32'h7FFF));
  endtask

  task automatic alu(input int op, input int dd, input int rd, input bit ld = 0,
                     input bit ret = 0, input bit tn = 0, input bit tr = 0, input bit st = 0);
    put({3'b011, ld, 4'(op), ret, tn, tr, st, 2'(rd), 2'(dd)});
  endtask

  task automatic raw_emit(input int k);
    lit(16'h4000 + k);
    alu(1, -1, 0, .st(1));
    alu(1, -1, 0);
  endtask

  task automatic emit(input int k, input int val, input string tag);
    raw_emit(k);
    q_addr.push_back(16'(16'h4000 + k));
    q_data.push_back(16'(val));
    q_tag.push_back(tag);
    n_exp++;
  endtask

  task automatic binop(input int a, input int b, input int op, input int exp, input string tag);
    lit(a);
    lit(b);
    alu(op, -1, 0);
    emit(n_exp, exp, tag);
  endtask

  int gA, gB, gC;

  task automatic rchk(input string what);
    nchk++;
    if (mem_raddr !== 12'd0 || io_wr !== 1'b0 || mem_we !== 1'b0 || io_rd !== 1'b0) begin
      nfail++;
      $display("FAIL R1 %s raddr=%h we=%b iowr=%b iord=%b, expected 0 0 0 0", what, mem_raddr, mem_we, io_wr, io_rd);
    end
  endtask

  task automatic gap(input int i, input int j, input int want, input string tag);
    nchk++;
    if (wr_cyc[j] - wr_cyc[i] != want) begin
      nfail++;
      $display("FAIL %s cycle gap=%0d, expected %0d", tag, wr_cyc[j] - wr_cyc[i], want);
    end
  endtask

  initial begin
    // R11 depth while stack starts empty (two pushes)
    lit(9); lit(9); alu(14, 1, 0, .tn(1)); emit(n_exp, 2, "R11");
    alu(1, -1, 0); alu(1, -1, 0);
    // R6 operation set
    binop(5, 3, 2, 8, "R6");
    binop(5, 3, 12, 2, "R6");
    binop(3, 5, 12, 16'hFFFE, "R6");
    binop(16'h0F0F, 16'h00FF, 3, 16'h000F, "R6");
    binop(16'h0F0F, 16'h00FF, 4, 16'h0FFF, "R6");
    binop(16'h0F0F, 16'h00FF, 5, 16'h0FF0, "R6");
    lit(0); alu(6, 0, 0); emit(n_exp, 16'hFFFF, "R6");
    binop(7, 7, 7, 16'hFFFF, "R6");
    binop(7, 6, 7, 0, "R6");
    lit(0); alu(6, 0, 0); lit(1); alu(8, -1, 0); emit(n_exp, 16'hFFFF, "R6");
    lit(0); alu(6, 0, 0); lit(1); alu(15, -1, 0); emit(n_exp, 0, "R6");
    binop(1, 2, 15, 16'hFFFF, "R6");
    binop(1, 4, 13, 16, "R6");
    binop(16'h100, 4, 9, 16'h10, "R6");
    lit(0); alu(10, 0, 0); emit(n_exp, 16'hFFFF, "R6");
    binop(6, 4, 1, 6, "R6");
    binop(6, 4, 0, 4, "R6");
    // R2 widest literal
    lit(16'h7FFF); emit(n_exp, 16'h7FFF, "R2");
    // R5 T to R and back through R
    lit(16'h66); alu(1, -1, 1, .tr(1)); alu(11, 1, -1, .tn(1)); emit(n_exp, 16'h66, "R5");
    // R4 call and return
    put({3'b010, 13'h100}); emit(n_exp, 16'h77, "R4");
    // R3 jumps
    put({3'b000, 13'(pa + 5)}); lit(16'hBAD); raw_emit(60);
    lit(0); put({3'b001, 13'(pa + 5)}); lit(16'hBAD); raw_emit(61);
    lit(1); put({3'b001, 13'(pa + 5)}); lit(16'h11); emit(n_exp, 16'h11, "R3");
    lit(16'h22); emit(n_exp, 16'h22, "R3");
    // R7 store to memory, then load back; R8 stall timing
    lit(16'h1234); lit(16'h200); alu(1, -1, 0, .st(1)); alu(1, -1, 0);
    lit(16'h200); alu(0, 0, 0, .ld(1)); emit(n_exp, 16'h1234, "R7"); gA = n_exp - 1;
    lit(16'h200); alu(0, 0, 0, .ld(1)); emit(n_exp, 16'h1234, "R8"); gB = n_exp - 1;
    lit(16'h200); alu(0, 0, 0); emit(n_exp, 16'h200, "R9"); gC = n_exp - 1;
    // R8 I/O read through the alternate cycle
    lit(16'h4005); alu(0, 0, 0, .ld(1)); emit(n_exp, 16'h5A05, "R8");
    // R10 wrap: 18 pushes, 17 pops leaves the overwritten slot on top
    for (int i = 1; i <= 18; i++) lit(i);
    for (int i = 0; i < 17; i++) alu(1, -1, 0);
    emit(n_exp, 17, "R10");
    alu(1, -1, 0);
    put({3'b000, 13'(pa)});
    pa = 16'h100;
    lit(16'h77); alu(0, 0, -1, .ret(1));
    @(negedge clk);
    ld_we = 1'b0;
    repeat (2) @(negedge clk);
    rchk("during reset");
    rst = 1'b0;
    #1 rchk("first cycle after reset");
    while (q_data.size() > 0 && cyc < 20000) @(posedge clk);
    repeat (40) @(posedge clk);
    @(negedge clk);
    if (q_data.size() > 0) begin
      nchk++; nfail++;
      $display("FAIL R3 watchdog: %0d writes missing, expected 0", q_data.size());
    end else begin
      gap(gA, gB, 6, "R8");
      gap(gB, gC, 5, "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule